// File: doc/BRIEF.md
# Three-Stage Escalating Watchdog Timer

A single-channel watchdog with a small register interface. Software programs a reload length and an escalation policy, then keeps the timer alive by writing a restart command. A free-running prescaler produces one count tick every `PRESC` clocks, and a down-counter loads with the length value shifted left by `LOW_W` bits, so the lowest bits always start at zero. Each time the counter runs out, it reloads and the escalation advances one stage. The first stage raises a core interrupt that software treats as an early warning. The second stage can raise a secondary interrupt for a management processor. The third stage raises a reset request.

The policy field picks how far the escalation goes: stopped, core interrupt only, core plus secondary interrupt, or the full three-stage sequence ending in reset. The core interrupt has a write-one-to-clear pending bit and an enable bit. The enable is set through one address and cleared through another, so no read-modify-write is needed. The reset request stays asserted until the system reset, and a clock manager or reset controller outside this block acts on it.

Top module: `wdt_stage_top`

## Requirements
- R1: The control word sits at address 0. Bits [1:0] hold the policy and bit 2 holds the secondary-interrupt enable. Bits [4 +: LEN_W] hold the length, and reads return the live count at bits [20 +: LEN_W+LOW_W]. A write to the control word loads the counter with length<<LOW_W, restarts the prescaler and returns the escalation to its first stage.
- R2: While the policy is nonzero and the sequence has not ended, the counter decrements exactly once every PRESC clocks, counted from the last load.
- R3: A tick that finds the count at 0 or 1 is an expiry, so a length of 0 expires on the first tick. An expiry reloads the counter. The first-stage expiry sets the pending bit whatever the enable state, and the pending bit reads at address 1, bit 0. Under policy 1, every expiry sets the pending bit.
- R4: Under policies 2 and 3, the second expiry raises the secondary interrupt only when bit 2 of the control word is set. In every case, the second expiry advances to the third stage. The secondary interrupt stays high until a restart, a control write or a system reset.
- R5: Under policy 3, the third expiry raises the reset request and the timer stops. Under policy 2, later expiries produce no further event.
- R6: Writing data bit 0 = 1 to address 4 reloads the counter to the full length, restarts the prescaler and returns to the first stage, which clears the secondary interrupt. A write there with bit 0 = 0 changes nothing.
- R7: Once the reset request is high, it stays high through restarts and control writes. Only the system reset clears it.
- R8: Writing 1 to bit 0 of address 1 clears the pending bit, and writing 0 there does nothing. Bit 0 written as 1 at address 2 sets the enable, and at address 3 it clears the enable. Addresses 2 and 3 both read the enable at bit 0. The core interrupt equals pending AND enable.
- R9: Policy 0 holds the count and prescaler still, and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | DATA_W | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | DATA_W | Combinational read data |
| coreIrq | output | 1 | Core interrupt (pending AND enable) |
| secIrq | output | 1 | Secondary interrupt |
| rstReq | output | 1 | Sticky reset request |

## Verification
A write lands on the clock edge where wrEn is sampled. The first tick after that edge comes PRESC clocks later, so expiry k of a length L falls exactly k·(L<<LOW_W)·PRESC clocks after the edge, and the event outputs change on that edge. The bench samples on falling edges: it checks once half a clock before a due edge to see the old value, and once half a clock after it to see the new one. Register effects, such as clearing the pending bit or changing the enable, show one clock after the write, and reads are taken from the combinational read port within the same low phase.

// File: rtl/wdt_stage_pkg.sv
package wdt_stage_pkg;

  // register addresses
  localparam logic [2:0] ADDR_CTRL    = 3'd0;
  localparam logic [2:0] ADDR_PEND    = 3'd1;
  localparam logic [2:0] ADDR_ENA_SET = 3'd2;
  localparam logic [2:0] ADDR_ENA_CLR = 3'd3;
  localparam logic [2:0] ADDR_POKE    = 3'd4;

  // control word field positions
  localparam int MODE_LSB = 0;
  localparam int SEC_BIT  = 2;
  localparam int LEN_LSB  = 4;
  localparam int CNT_LSB  = 20;

  typedef enum logic [1:0] {
    MODE_STOP        = 2'd0,
    MODE_IRQ         = 2'd1,
    MODE_IRQ_SEC     = 2'd2,
    MODE_IRQ_SEC_RST = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    STG_FIRST  = 2'd0,
    STG_SECOND = 2'd1,
    STG_THIRD  = 2'd2,
    STG_DONE   = 2'd3
  } stage_e;

  // strobes from control to datapath
  typedef struct packed {
    logic reload;
    logic run;
  } dpStrobe_t;

endpackage

// File: rtl/wdt_stage_datapath.sv
module wdt_stage_datapath
  import wdt_stage_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int LOW_W = 8,
  parameter int PRESC = 1024,
  localparam int CNT_W = LEN_W + LOW_W,
  localparam int PS_W  = $clog2(PRESC)
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        strobe,
  input  logic [LEN_W-1:0] loadLen,
  output logic             expire,
  output logic [CNT_W-1:0] count
);

  logic [PS_W-1:0]  prescQ;
  logic [CNT_W-1:0] reloadVal;
  logic             tick;
  logic             runOut;

  assign reloadVal = {loadLen, {LOW_W{1'b0}}};
  assign tick      = strobe.run && (prescQ == PS_W'(PRESC - 1));
  assign runOut    = (count <= CNT_W'(1));
  assign expire    = tick && !strobe.reload && runOut;

  always_ff @(posedge clk) begin
    if (rst) begin
      prescQ <= '0;
      count  <= '0;
    end else if (strobe.reload) begin
      prescQ <= '0;
      count  <= reloadVal;
    end else if (strobe.run) begin
      prescQ <= tick ? '0 : prescQ + PS_W'(1);
      if (tick) begin
        count <= runOut ? reloadVal : count - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/wdt_stage_ctrl.sv
module wdt_stage_ctrl
  import wdt_stage_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              expire,
  output dpStrobe_t         strobe,
  output logic [LEN_W-1:0]  loadLen,
  output mode_e             modeQ,
  output logic              secEnQ,
  output logic [LEN_W-1:0]  lenQ,
  output stage_e            stageQ,
  output logic              pendQ,
  output logic              enaQ,
  output logic              coreIrq,
  output logic              secIrq,
  output logic              rstReq
);

  logic ctrlWr, pokeWr, pendClr, enaSet, enaClr;
  logic secAllowed;
  logic unusedWr;

  assign unusedWr = ^{wrData[3], wrData[DATA_W-1:LEN_LSB+LEN_W]};

  assign ctrlWr  = wrEn && (wrAddr == ADDR_CTRL);
  assign pokeWr  = wrEn && (wrAddr == ADDR_POKE) && wrData[0];
  assign pendClr = wrEn && (wrAddr == ADDR_PEND) && wrData[0];
  assign enaSet  = wrEn && (wrAddr == ADDR_ENA_SET) && wrData[0];
  assign enaClr  = wrEn && (wrAddr == ADDR_ENA_CLR) && wrData[0];

  assign loadLen       = ctrlWr ? wrData[LEN_LSB +: LEN_W] : lenQ;
  assign strobe.reload = ctrlWr || pokeWr;
  assign strobe.run    = (modeQ != MODE_STOP) && (stageQ != STG_DONE);

  assign secAllowed = (modeQ == MODE_IRQ_SEC) || (modeQ == MODE_IRQ_SEC_RST);
  assign coreIrq    = pendQ && enaQ;

  // configuration
  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ  <= MODE_STOP;
      secEnQ <= 1'b0;
      lenQ   <= '0;
    end else if (ctrlWr) begin
      modeQ  <= mode_e'(wrData[MODE_LSB +: 2]);
      secEnQ <= wrData[SEC_BIT];
      lenQ   <= wrData[LEN_LSB +: LEN_W];
    end
  end

  // interrupt enable and pending
  always_ff @(posedge clk) begin
    if (rst) begin
      enaQ  <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      if (enaSet) enaQ <= 1'b1;
      else if (enaClr) enaQ <= 1'b0;
      if (expire && stageQ == STG_FIRST) pendQ <= 1'b1;
      else if (pendClr) pendQ <= 1'b0;
    end
  end

  // escalation stage and secondary interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      stageQ <= STG_FIRST;
      secIrq <= 1'b0;
    end else if (strobe.reload) begin
      stageQ <= STG_FIRST;
      secIrq <= 1'b0;
    end else if (expire) begin
      case (stageQ)
        STG_FIRST: if (modeQ != MODE_IRQ) stageQ <= STG_SECOND;
        STG_SECOND: begin
          if (secEnQ && secAllowed) secIrq <= 1'b1;
          stageQ <= STG_THIRD;
        end
        STG_THIRD: if (modeQ == MODE_IRQ_SEC_RST) stageQ <= STG_DONE;
        default: stageQ <= stageQ;
      endcase
    end
  end

  // sticky reset request
  always_ff @(posedge clk) begin
    if (rst) begin
      rstReq <= 1'b0;
    end else if (expire && stageQ == STG_THIRD && modeQ == MODE_IRQ_SEC_RST) begin
      rstReq <= 1'b1;
    end
  end

endmodule

// File: rtl/wdt_stage_top.sv
module wdt_stage_top
  import wdt_stage_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 16,
  parameter int LOW_W  = 8,
  parameter int PRESC  = 1024,
  localparam int CNT_W = LEN_W + LOW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              coreIrq,
  output logic              secIrq,
  output logic              rstReq
);

  dpStrobe_t        strobe;
  logic [LEN_W-1:0] loadLen;
  logic [LEN_W-1:0] lenQ;
  logic [CNT_W-1:0] count;
  logic             expire;
  mode_e            modeQ;
  stage_e           stageQ;
  logic             secEnQ, pendQ, enaQ;

  wdt_stage_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .expire(expire), .strobe(strobe), .loadLen(loadLen), .modeQ(modeQ),
    .secEnQ(secEnQ), .lenQ(lenQ), .stageQ(stageQ), .pendQ(pendQ),
    .enaQ(enaQ), .coreIrq(coreIrq), .secIrq(secIrq), .rstReq(rstReq)
  );

  wdt_stage_datapath #(.LEN_W(LEN_W), .LOW_W(LOW_W), .PRESC(PRESC)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .loadLen(loadLen),
    .expire(expire), .count(count)
  );

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_CTRL: begin
        rdData[MODE_LSB +: 2]     = modeQ;
        rdData[SEC_BIT]           = secEnQ;
        rdData[LEN_LSB +: LEN_W]  = lenQ;
        rdData[CNT_LSB +: CNT_W]  = count;
      end
      ADDR_PEND:    rdData[0] = pendQ;
      ADDR_ENA_SET,
      ADDR_ENA_CLR: rdData[0] = enaQ;
      default:      rdData = '0;
    endcase
  end

endmodule

// File: rtl/wdt_stage_checker.sv
module wdt_stage_checker
  import wdt_stage_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [2:0]        wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              expire,
  input mode_e             modeQ,
  input stage_e            stageQ,
  input logic              secEnQ,
  input logic              pendQ,
  input logic              secIrq,
  input logic              rstReq
);

  a_r7_reset_sticky: assert property (@(posedge clk) disable iff (rst)
    rstReq |=> rstReq);

  a_r5_reset_only_policy3: assert property (@(posedge clk) disable iff (rst)
    $rose(rstReq) |-> (modeQ == MODE_IRQ_SEC_RST) && (stageQ == STG_DONE));

  a_r4_sec_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(secIrq) |-> secEnQ && (modeQ != MODE_STOP) && (modeQ != MODE_IRQ));

  a_r6_poke_restarts: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == ADDR_POKE && wrData[0]) |=> (stageQ == STG_FIRST) && !secIrq);

  a_r8_pending_w1c: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == ADDR_PEND && wrData[0] && !expire) |=> !pendQ);

  a_r9_stop_quiet: assert property (@(posedge clk) disable iff (rst)
    (modeQ == MODE_STOP) |=> !$rose(pendQ) && !$rose(secIrq) && !$rose(rstReq));

endmodule

bind wdt_stage_top wdt_stage_checker #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .expire(expire), .modeQ(modeQ), .stageQ(stageQ), .secEnQ(secEnQ),
  .pendQ(pendQ), .secIrq(secIrq), .rstReq(rstReq)
);

// File: tb/wdt_stage_tb.sv
module wdt_stage_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 64;
  localparam int LEN_W  = 16;
  localparam int LOW_W  = 2;
  localparam int PRESC  = 4;
  localparam int CNT_W  = LEN_W + LOW_W;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_PEND = 3'd1;
  localparam logic [2:0] A_ESET = 3'd2;
  localparam logic [2:0] A_ECLR = 3'd3;
  localparam logic [2:0] A_POKE = 3'd4;

  typedef struct packed {
    logic [1:0] mode;
    logic       sec;
    logic [3:0] len;
    logic [1:0] nExp;
    logic       expCore;
    logic       expSec;
    logic       expRst;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 1'b0, 4'd1, 2'd1, 1'b1, 1'b0, 1'b0},
    '{2'd1, 1'b1, 4'd1, 2'd3, 1'b1, 1'b0, 1'b0},
    '{2'd2, 1'b1, 4'd1, 2'd2, 1'b1, 1'b1, 1'b0},
    '{2'd2, 1'b0, 4'd2, 2'd2, 1'b1, 1'b0, 1'b0},
    '{2'd2, 1'b1, 4'd1, 2'd3, 1'b1, 1'b1, 1'b0},
    '{2'd3, 1'b1, 4'd1, 2'd3, 1'b1, 1'b1, 1'b1},
    '{2'd3, 1'b0, 4'd2, 2'd3, 1'b1, 1'b0, 1'b1},
    '{2'd3, 1'b1, 4'd1, 2'd2, 1'b1, 1'b1, 1'b0},
    '{2'd0, 1'b1, 4'd1, 2'd3, 1'b0, 1'b0, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wrEn = 1'b0;
  logic [2:0]        wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [2:0]        rdAddr = '0;
  logic [DATA_W-1:0] rdData;
  logic              coreIrq, secIrq, rstReq;

  int nTests = 0;
  int nFail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_stage_top #(.DATA_W(DATA_W), .LEN_W(LEN_W), .LOW_W(LOW_W), .PRESC(PRESC)) dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .coreIrq(coreIrq), .secIrq(secIrq),
    .rstReq(rstReq)
  );

  task automatic chk(input string tag, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; wrEn = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // drives at a falling edge, lands on the next rising edge, returns half a clock later
  task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DATA_W-1:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  function automatic logic [DATA_W-1:0] ctrlWord(input logic [1:0] m, input logic s,
                                                 input logic [LEN_W-1:0] l);
    ctrlWord = (DATA_W'(l) << 4) | (DATA_W'(s) << 2) | DATA_W'(m);
  endfunction

  function automatic logic [DATA_W-1:0] cntOf(input logic [DATA_W-1:0] v);
    cntOf = (v >> 20) & ((DATA_W'(1) << CNT_W) - 1);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] v;

    // reset state
    doReset();
    chk("R7 reset coreIrq", DATA_W'(coreIrq), 0);
    chk("R7 reset secIrq", DATA_W'(secIrq), 0);
    chk("R7 reset rstReq", DATA_W'(rstReq), 0);
    rd(A_CTRL, v);
    chk("R1 reset control word", v, 0);

    // table of policies
    for (int i = 0; i < NVEC; i++) begin
      int waitCyc;
      doReset();
      wr(A_ESET, 1);
      wr(A_CTRL, ctrlWord(VECS[i].mode, VECS[i].sec, LEN_W'(VECS[i].len)));
      waitCyc = int'(VECS[i].nExp) * int'(VECS[i].len) * (1 << LOW_W) * PRESC;
      repeat (waitCyc) @(negedge clk);
      chk($sformatf("R3 vec%0d coreIrq", i), DATA_W'(coreIrq), DATA_W'(VECS[i].expCore));
      chk($sformatf("R4 vec%0d secIrq", i), DATA_W'(secIrq), DATA_W'(VECS[i].expSec));
      chk($sformatf("R5 vec%0d rstReq", i), DATA_W'(rstReq), DATA_W'(VECS[i].expRst));
    end

    // R1 readback and R2 prescale
    doReset();
    wr(A_CTRL, ctrlWord(2'd3, 1'b1, 16'd3));
    rd(A_CTRL, v);
    chk("R1 control readback", v, (DATA_W'(12) << 20) | ctrlWord(2'd3, 1'b1, 16'd3));
    repeat (PRESC - 1) @(negedge clk);
    rd(A_CTRL, v);
    chk("R2 count before tick", cntOf(v), 12);
    @(negedge clk);
    rd(A_CTRL, v);
    chk("R2 count after tick", cntOf(v), 11);

    // R3 exact first expiry and repetition under policy 1
    doReset();
    wr(A_ESET, 1);
    wr(A_CTRL, ctrlWord(2'd1, 1'b0, 16'd1));
    repeat (15) @(negedge clk);
    chk("R3 no irq before expiry", DATA_W'(coreIrq), 0);
    @(negedge clk);
    chk("R3 irq at expiry", DATA_W'(coreIrq), 1);
    wr(A_PEND, 1);
    repeat (14) @(negedge clk);
    rd(A_PEND, v);
    chk("R3 pending clear before 2nd expiry", v, 0);
    @(negedge clk);
    chk("R3 policy1 repeats irq", DATA_W'(coreIrq), 1);

    // R8 enable and pending registers
    wr(A_ECLR, 1);
    chk("R8 enable clear masks irq", DATA_W'(coreIrq), 0);
    wr(A_PEND, 0);
    rd(A_PEND, v);
    chk("R8 write 0 keeps pending", v, 1);
    wr(A_ESET, 1);
    chk("R8 enable set shows irq", DATA_W'(coreIrq), 1);
    wr(A_PEND, 1);
    chk("R8 w1c clears irq", DATA_W'(coreIrq), 0);
    wr(A_ECLR, 1);
    rd(A_ESET, v);
    chk("R8 enable reads 0", v, 0);
    repeat (11) @(negedge clk);
    rd(A_PEND, v);
    chk("R3 pending set with enable off", v, 1);
    chk("R8 irq masked while disabled", DATA_W'(coreIrq), 0);

    // R6 poke restarts escalation
    doReset();
    wr(A_ESET, 1);
    wr(A_CTRL, ctrlWord(2'd3, 1'b1, 16'd1));
    repeat (24) @(negedge clk);
    wr(A_POKE, 1);
    repeat (47) @(negedge clk);
    chk("R6 no reset before restarted 3rd expiry", DATA_W'(rstReq), 0);
    chk("R4 secondary after restarted 2nd expiry", DATA_W'(secIrq), 1);
    @(negedge clk);
    chk("R5 reset at restarted 3rd expiry", DATA_W'(rstReq), 1);

    // R7 sticky reset request
    wr(A_POKE, 1);
    chk("R6 poke clears secondary", DATA_W'(secIrq), 0);
    wr(A_CTRL, ctrlWord(2'd0, 1'b0, 16'd1));
    repeat (5) @(negedge clk);
    chk("R7 reset request stays", DATA_W'(rstReq), 1);
    doReset();
    chk("R7 system reset clears", DATA_W'(rstReq), 0);

    // R6 poke with bit0 = 0 ignored
    wr(A_CTRL, ctrlWord(2'd1, 1'b0, 16'd2));
    repeat (8) @(negedge clk);
    wr(A_POKE, 0);
    rd(A_CTRL, v);
    chk("R6 poke data 0 ignored", cntOf(v), 6);
    wr(A_POKE, 1);
    rd(A_CTRL, v);
    chk("R6 poke reloads", cntOf(v), 8);

    // R9 stop policy
    doReset();
    wr(A_ESET, 1);
    wr(A_CTRL, ctrlWord(2'd1, 1'b0, 16'd2));
    repeat (6) @(negedge clk);
    wr(A_CTRL, ctrlWord(2'd0, 1'b1, 16'd2));
    repeat (100) @(negedge clk);
    rd(A_CTRL, v);
    chk("R9 count held", cntOf(v), 8);
    chk("R9 no core irq", DATA_W'(coreIrq), 0);
    chk("R9 no reset", DATA_W'(rstReq), 0);

    // R3 zero length boundary
    doReset();
    wr(A_ESET, 1);
    wr(A_CTRL, ctrlWord(2'd1, 1'b0, 16'd0));
    repeat (PRESC - 1) @(negedge clk);
    chk("R3 len0 before first tick", DATA_W'(coreIrq), 0);
    @(negedge clk);
    chk("R3 len0 expires on first tick", DATA_W'(coreIrq), 1);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule